// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block evaluates postfix (reverse Polish) expressions on a stack of signed two's-complement words. The entries nearest the top sit in a small window of registers. Deeper entries move to an internal backing store. Each command either pushes an operand or applies a binary operation to the two topmost entries: add, subtract, multiply or divide. The operation removes both entries and pushes the result.

The register window is a circular buffer described by a head index and an occupancy count, so data never shifts between registers. Traffic to the backing store happens only at the window's edges. A push onto a full window first writes the deepest register entry out to the store. An operation that leaves the window one short, while the store still holds entries, reads one entry back into the bottom slot.

Commands use a valid/ready handshake. Each store write or read costs one extra cycle, during which ready is low. The block shows the current top of stack and the total depth, and it keeps separate counts of implicit stores and implicit fetches.

Top module: `stack_cache_eval`

## Requirements
- R1: After reset the stack is empty. Ready is high, top_valid is low, depth is 0, both counters are 0, and both flags are low.
- R2: A push command (cmd_op = 0) that is accepted puts cmd_data on top and raises depth by one. The results appear on the outputs after the next clock edge.
- R3: An accepted operation takes the top entry as t and the entry below it as s. It replaces both with one result: add (op 1) gives s+t, subtract (op 2) gives s-t, multiply (op 3) gives the low W bits of s*t, and divide (op 4) gives the signed quotient s/t truncated toward zero. Depth falls by one.
- R4: A push onto a full register window writes exactly one entry to the backing store and increments store_cnt by one. Every spilled value returns later, in last-in first-out order.
- R5: An operation accepted while the backing store is non-empty reads exactly one entry back and increments fetch_cnt by one. No other operation changes fetch_cnt.
- R6: A command that causes a spill or a fill holds cmd_ready low for exactly the following cycle. Any other accepted command leaves ready high.
- R7: Dividing by zero gives all-ones. The div_zero flag then stays high until reset.
- R8: The block rejects three kinds of command: an operation with fewer than two entries in total, a push when the window and the store are both full, and an opcode from 5 to 7. A rejected command raises cmd_err for the one cycle after acceptance and leaves depth, top and counters unchanged.
- R9: Take the sequence a b c * + a d c * + e - /. With a 2-entry window it causes exactly 4 stores and 4 fetches. With a 4-entry window it causes none. Both windows give the same final result.
- R10: Only spills and fills change store_cnt and fetch_cnt, each by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | 0 push, 1 add, 2 sub, 3 mul, 4 div |
| cmd_data | input | W | Operand for push |
| top_valid | output | 1 | Stack holds at least one entry |
| top_data | output | W | Current top entry |
| depth | output | DW | Total entries (window plus store) |
| store_cnt | output | CNT_W | Implicit stores so far |
| fetch_cnt | output | CNT_W | Implicit fetches so far |
| cmd_err | output | 1 | One-cycle pulse after a rejected command |
| div_zero | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench builds two copies that take the same command stream. The first has a 2-entry window and a 4-entry store, for a total capacity of 6. Nearly every push therefore spills, and random streams reach the full-store rejection quickly. The second has a 4-entry window and an 8-entry store. It shows the reference expression running with no memory traffic, and it exercises index wrap-around in a larger ring. Running both copies together also shows that the window size changes only the traffic and the stall cycles, never the results.

// File: rtl/sce_pkg.sv
package sce_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } sce_op_e;

endpackage

// File: rtl/sce_alu.sv
module sce_alu #(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] result,
    output logic         by_zero
);
    import sce_pkg::*;

    logic signed [W-1:0] s_lhs;
    logic signed [W-1:0] s_rhs;

    assign s_lhs = lhs;
    assign s_rhs = rhs;

    always_comb begin
        by_zero = 1'b0;
        result  = '0;
        case (op)
            OP_ADD: result = lhs + rhs;
            OP_SUB: result = lhs - rhs;
            OP_MUL: result = lhs * rhs;
            OP_DIV: begin
                if (rhs == '0) begin
                    by_zero = 1'b1;
                    result  = '1;
                end else begin
                    result = s_lhs / s_rhs;
                end
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/sce_backing_mem.sv
module sce_backing_mem #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/stack_cache_eval.sv
module stack_cache_eval #(
    parameter int W         = 16,
    parameter int N         = 2,
    parameter int MEM_DEPTH = 16,
    parameter int CNT_W     = 16,
    localparam int DW       = $clog2(N + MEM_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [W-1:0]     cmd_data,
    output logic             top_valid,
    output logic [W-1:0]     top_data,
    output logic [DW-1:0]    depth,
    output logic [CNT_W-1:0] store_cnt,
    output logic [CNT_W-1:0] fetch_cnt,
    output logic             cmd_err,
    output logic             div_zero
);
    import sce_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(N + 1);
    localparam int PW = $clog2(MEM_DEPTH + 1);
    localparam int AW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
    localparam logic [CW-1:0] WIN_FULL = CW'(N);
    localparam logic [PW-1:0] MEM_FULL = PW'(MEM_DEPTH);

    typedef struct packed {
        logic [N-1:0][W-1:0] regs;
        logic [IW-1:0]       head;
        logic [CW-1:0]       cnt;
        logic [PW-1:0]       mptr;
        logic [CNT_W-1:0]    st_cnt;
        logic [CNT_W-1:0]    fe_cnt;
        logic                stall;
        logic                err;
        logic                dz;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] i);
        return (i == IW'(N - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [IW-1:0] ring_prev(input logic [IW-1:0] i);
        return (i == '0) ? IW'(N - 1) : i - 1'b1;
    endfunction

    logic [IW-1:0] head_nx, head_pv;
    logic [W-1:0]  alu_res;
    logic          alu_dz;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [W-1:0]  mem_wdata, mem_rdata;
    logic [DW-1:0] total;
    logic          accept;

    assign head_nx   = ring_next(s_q.head);
    assign head_pv   = ring_prev(s_q.head);
    assign total     = DW'(s_q.cnt) + DW'(s_q.mptr);
    assign accept    = cmd_valid && !s_q.stall;
    assign mem_waddr = AW'(s_q.mptr);
    assign mem_raddr = AW'(s_q.mptr - 1'b1);
    assign mem_wdata = s_q.regs[head_nx];

    sce_alu #(.W(W)) u_alu (
        .op      (cmd_op),
        .lhs     (s_q.regs[head_pv]),
        .rhs     (s_q.regs[s_q.head]),
        .result  (alu_res),
        .by_zero (alu_dz)
    );

    sce_backing_mem #(.W(W), .DEPTH(MEM_DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        s_d.stall = 1'b0;
        mem_we    = 1'b0;
        if (accept) begin
            if (cmd_op == OP_PUSH) begin
                if (s_q.cnt == WIN_FULL) begin
                    if (s_q.mptr == MEM_FULL) begin
                        s_d.err = 1'b1;
                    end else begin
                        // spill the deepest slot, then reuse it as the new top
                        mem_we             = 1'b1;
                        s_d.regs[head_nx]  = cmd_data;
                        s_d.head           = head_nx;
                        s_d.mptr           = s_q.mptr + 1'b1;
                        s_d.st_cnt         = s_q.st_cnt + 1'b1;
                        s_d.stall          = 1'b1;
                    end
                end else begin
                    s_d.regs[head_nx] = cmd_data;
                    s_d.head          = head_nx;
                    s_d.cnt           = s_q.cnt + 1'b1;
                end
            end else if (cmd_op == OP_ADD || cmd_op == OP_SUB ||
                         cmd_op == OP_MUL || cmd_op == OP_DIV) begin
                if (total < DW'(2)) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.regs[head_pv] = alu_res;
                    s_d.head          = head_pv;
                    if (alu_dz) begin
                        s_d.dz = 1'b1;
                    end
                    if (s_q.mptr != '0) begin
                        // refill the freed old-top slot, which is now the bottom
                        s_d.regs[s_q.head] = mem_rdata;
                        s_d.mptr           = s_q.mptr - 1'b1;
                        s_d.fe_cnt         = s_q.fe_cnt + 1'b1;
                        s_d.stall          = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready = !s_q.stall;
    assign top_valid = (s_q.cnt != '0);
    assign top_data  = s_q.regs[s_q.head];
    assign depth     = total;
    assign store_cnt = s_q.st_cnt;
    assign fetch_cnt = s_q.fe_cnt;
    assign cmd_err   = s_q.err;
    assign div_zero  = s_q.dz;

endmodule

// File: rtl/sce_chk.sv
module sce_chk #(
    parameter int N         = 2,
    parameter int MEM_DEPTH = 16,
    parameter int CNT_W     = 16,
    parameter int DW        = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic [DW-1:0]    depth,
    input logic [CNT_W-1:0] store_cnt,
    input logic [CNT_W-1:0] fetch_cnt,
    input logic             cmd_err,
    input logic             div_zero
);
    // R6
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready);

    // R6
    spill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_cnt != $past(store_cnt)) |-> !cmd_ready);

    // R5
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_cnt != $past(fetch_cnt)) |-> !cmd_ready);

    // R10
    store_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_cnt == $past(store_cnt)) || (store_cnt == CNT_W'($past(store_cnt) + 1'b1)));

    // R10
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_cnt == $past(fetch_cnt)) || (fetch_cnt == CNT_W'($past(fetch_cnt) + 1'b1)));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($stable(depth) && $stable(store_cnt) && $stable(fetch_cnt)));

    // R7
    div0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(div_zero) |-> div_zero);

    // R8
    depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(N + MEM_DEPTH));

endmodule

bind stack_cache_eval sce_chk #(
    .N(N), .MEM_DEPTH(MEM_DEPTH), .CNT_W(CNT_W), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .depth     (depth),
    .store_cnt (store_cnt),
    .fetch_cnt (fetch_cnt),
    .cmd_err   (cmd_err),
    .div_zero  (div_zero)
);

// File: tb/tb_stack_cache_eval.sv
module tb_stack_cache_eval;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [W-1:0] cmd_data = '0;

    logic rdy [2];
    logic tv [2];
    logic [W-1:0] top [2];
    logic [15:0] sc [2];
    logic [15:0] fc [2];
    logic er [2];
    logic dz [2];
    logic [2:0] dep0;
    logic [3:0] dep1;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_cache_eval #(.W(W), .N(2), .MEM_DEPTH(4), .CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy[0]),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .top_valid(tv[0]), .top_data(top[0]),
        .depth(dep0), .store_cnt(sc[0]), .fetch_cnt(fc[0]), .cmd_err(er[0]),
        .div_zero(dz[0]));

    stack_cache_eval #(.W(W), .N(4), .MEM_DEPTH(8), .CNT_W(16)) dut_w4 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy[1]),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .top_valid(tv[1]), .top_data(top[1]),
        .depth(dep1), .store_cnt(sc[1]), .fetch_cnt(fc[1]), .cmd_err(er[1]),
        .div_zero(dz[1]));

    // reference model state per instance
    int nreg [2] = '{2, 4};
    int ncap [2] = '{6, 12};
    logic [W-1:0] mstk [2][16];
    int msp [2];
    int mst [2];
    int mft [2];
    bit mdz [2];

    function automatic logic [W-1:0] ref_alu(input logic [2:0] op,
                                             input logic [W-1:0] s, input logic [W-1:0] t);
        logic signed [W-1:0] ss, st;
        ss = s;
        st = t;
        case (op)
            3'd1: return s + t;
            3'd2: return s - t;
            3'd3: return s * t;
            default: return (t == '0) ? '1 : W'(ss / st);
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            msp[m] = 0; mst[m] = 0; mft[m] = 0; mdz[m] = 1'b0;
        end
    endtask

    task automatic model_apply(input int m, input logic [2:0] op, input logic [W-1:0] v,
                               output bit e, output bit st);
        logic [W-1:0] s, t;
        e = 1'b0;
        st = 1'b0;
        if (op == 3'd0) begin
            if (msp[m] == ncap[m]) e = 1'b1;
            else begin
                if (msp[m] >= nreg[m]) begin mst[m]++; st = 1'b1; end
                mstk[m][msp[m]] = v;
                msp[m]++;
            end
        end else if (op <= 3'd4) begin
            if (msp[m] < 2) e = 1'b1;
            else begin
                t = mstk[m][msp[m]-1];
                s = mstk[m][msp[m]-2];
                if (op == 3'd4 && t == '0) mdz[m] = 1'b1;
                if (msp[m] > nreg[m]) begin mft[m]++; st = 1'b1; end
                msp[m]--;
                mstk[m][msp[m]-1] = ref_alu(op, s, t);
            end
        end else begin
            e = 1'b1;
        end
    endtask

    function automatic int dep_of(input int m);
        return (m == 0) ? int'(dep0) : int'(dep1);
    endfunction

    task automatic check_state(input int m, input bit e, input bit st, input string tag);
        chk("R6", "ready", int'(rdy[m]), int'(!st));
        chk("R8", "err", int'(er[m]), int'(e));
        chk(tag, "depth", dep_of(m), msp[m]);
        chk(tag, "top_valid", int'(tv[m]), int'(msp[m] > 0));
        if (msp[m] > 0) chk(tag, "top", int'(top[m]), int'(mstk[m][msp[m]-1]));
        chk("R4", "store_cnt", int'(sc[m]), mst[m]);
        chk("R5", "fetch_cnt", int'(fc[m]), mft[m]);
        chk("R7", "div_zero", int'(dz[m]), int'(mdz[m]));
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [W-1:0] v, input string tag);
        bit e [2];
        bit st [2];
        @(negedge clk);
        while (!(rdy[0] && rdy[1])) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_data = v;
        for (int m = 0; m < 2; m++) model_apply(m, op, v, e[m], st[m]);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int m = 0; m < 2; m++) check_state(m, e[m], st[m], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk("R1", "ready", int'(rdy[m]), 1);
            chk("R1", "top_valid", int'(tv[m]), 0);
            chk("R1", "depth", dep_of(m), 0);
            chk("R1", "store_cnt", int'(sc[m]), 0);
            chk("R1", "fetch_cnt", int'(fc[m]), 0);
            chk("R1", "err", int'(er[m]), 0);
            chk("R1", "div_zero", int'(dz[m]), 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // R9: reference postfix expression, a=7 b=3 c=5 d=2 e=4
        do_cmd(3'd0, 16'd7, "R9");
        do_cmd(3'd0, 16'd3, "R9");
        do_cmd(3'd0, 16'd5, "R9");
        do_cmd(3'd3, 16'd0, "R9");
        do_cmd(3'd1, 16'd0, "R9");
        do_cmd(3'd0, 16'd7, "R9");
        do_cmd(3'd0, 16'd2, "R9");
        do_cmd(3'd0, 16'd5, "R9");
        do_cmd(3'd3, 16'd0, "R9");
        do_cmd(3'd1, 16'd0, "R9");
        do_cmd(3'd0, 16'd4, "R9");
        do_cmd(3'd2, 16'd0, "R9");
        do_cmd(3'd4, 16'd0, "R9");
        chk("R9", "stores N=2", int'(sc[0]), 4);
        chk("R9", "fetches N=2", int'(fc[0]), 4);
        chk("R9", "stores N=4", int'(sc[1]), 0);
        chk("R9", "fetches N=4", int'(fc[1]), 0);
        chk("R9", "result N=2", int'(top[0]), 1);
        chk("R9", "result N=4", int'(top[1]), 1);

        // R8: operation on too few entries, bad opcode
        do_reset();
        do_cmd(3'd1, 16'd0, "R8");
        do_cmd(3'd0, 16'd11, "R2");
        do_cmd(3'd2, 16'd0, "R8");
        do_cmd(3'd6, 16'd0, "R8");

        // R3: each operation, signed values, multiply wrap
        do_cmd(3'd0, 16'd4, "R3");
        do_cmd(3'd2, 16'd0, "R3");
        do_cmd(3'd0, 16'd3, "R3");
        do_cmd(3'd3, 16'd0, "R3");
        do_cmd(3'd0, 16'hFFFC, "R3");
        do_cmd(3'd4, 16'd0, "R3");
        do_cmd(3'd0, 16'h4000, "R3");
        do_cmd(3'd0, 16'd4, "R3");
        do_cmd(3'd3, 16'd0, "R3");
        chk("R3", "mul low bits", int'(top[0]), 0);

        // R7: divide by zero and stickiness
        do_cmd(3'd0, 16'd0, "R7");
        do_cmd(3'd4, 16'd0, "R7");
        chk("R7", "div0 result", int'(top[0]), 16'hFFFF);
        do_cmd(3'd0, 16'd2, "R7");
        do_cmd(3'd1, 16'd0, "R7");

        // R4/R8: fill window and store, overflow, then drain LIFO
        do_reset();
        for (int i = 0; i < 7; i++) do_cmd(3'd0, W'(100 + i), "R4");
        for (int i = 0; i < 6; i++) do_cmd(3'd2, 16'd0, "R5");

        // random mix
        do_reset();
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [2:0] op;
            logic [W-1:0] v;
            r = int'($urandom % 20);
            v = (r < 10) ? W'($urandom % 4) : W'($urandom);
            if (r == 19) op = 3'd5 + 3'($urandom % 3);
            else if (msp[0] < 2 || msp[1] < 2 || r < 9) op = 3'd0;
            else op = 3'd1 + 3'($urandom % 4);
            do_cmd(op, v, "R10");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule